// File: doc/BRIEF.md
# Stereo Serial Audio Transmitter

This block moves stereo sample pairs from a converter core onto a three-wire serial audio link made of a word-select line, a bit clock and a data line. The core offers a parallel left/right pair of 24-bit two's complement words through a valid/ready handshake. The block then shifts each word out MSB first inside a 32-bit channel slot. The left slot of each frame is sent before the right slot.

The block has two roles on one pin set. As clock master it generates the bit clock and the word-select line from a one-cycle enable pulse that a separate ratio block supplies. Each enable pulse toggles the bit clock, so every frame has 64 bit-clock periods. As clock slave it follows an external bit clock and word select. It brings them into its own clock domain through two-flop synchronizers and acts on the synchronized falling edge. A format input picks I2S framing (0) or left-justified framing (1). This input may be changed while the block is held in reset.

One pair is held pending and is taken at the start of every left slot. If no pair is pending at that point, the last pair is sent again and a sticky underrun flag is raised.

Top module: `stereo_serial_tx`

## Requirements
- R1: Each 24-bit word is sent MSB first, one bit per bit-clock period. Every bit period of a 32-bit slot that does not carry a data bit drives the data line low. After reset the data line is low.
- R2: With fmt_lj=0 (I2S), the word-select line is low for the left slot and high for the right slot. The MSB occupies the second bit period of the slot, one period after the word-select transition.
- R3: With fmt_lj=1 (left-justified), the word-select line is high for the left slot and low for the right slot. The MSB occupies the first bit period of the slot, the same period in which word select changes.
- R4: In master mode, sdata_out and lrck_out change only in the system clock cycle in which sclk_out falls. A receiver therefore samples stable data on the rising bit-clock edge.
- R5: In master mode, sclk_out toggles once for each sclk_tick pulse and holds its level otherwise. Each slot lasts 32 bit-clock periods, and the frame starts with the left slot. After reset, sclk_out is low and lrck_out shows the right-slot level. clk_drive_en equals master_mode.
- R6: smp_ready is high while no pair is pending. A pair is accepted in a cycle with smp_valid and smp_ready both high, after which smp_ready is low until the pair is taken at the next left-slot start. The taken pair is sent in that left slot and in the right slot after it.
- R7: If no pair is pending at a left-slot start, the previous pair is sent again and underrun goes high. underrun stays high until reset and is low after reset.
- R8: In slave mode, sclk_in and lrck_in pass through two-flop synchronizers. sdata_out changes in the third system clock cycle after a falling sclk_in edge. The slot boundary is taken from the lrck_in level seen with that falling edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| master_mode | input | 1 | 1: generate bit clock and word select, 0: follow external ones |
| fmt_lj | input | 1 | Framing: 0 I2S, 1 left-justified |
| sclk_tick | input | 1 | Master-mode enable pulse; each pulse toggles the bit clock |
| sclk_in | input | 1 | External bit clock (slave mode) |
| lrck_in | input | 1 | External word select (slave mode) |
| smp_valid | input | 1 | Sample pair offered |
| smp_ready | output | 1 | Pending register empty, pair can be accepted |
| smp_left | input | 24 | Left sample, two's complement |
| smp_right | input | 24 | Right sample, two's complement |
| sclk_out | output | 1 | Generated bit clock (low in slave mode) |
| lrck_out | output | 1 | Generated word select (low in slave mode) |
| clk_drive_en | output | 1 | Output enable for the bit clock and word-select pins |
| sdata_out | output | 1 | Serial data |
| underrun | output | 1 | Sticky flag: a left slot started with no pending pair |

## Verification
The stream is sent in all four combinations of role and framing. The words include full-scale negative, full-scale positive, alternating bits, a lone LSB, all ones and random values. These separate a one-period offset error from a bit-order error, and they expose a swapped channel or a wrong word-select polarity in each framing. One master run withholds a pair for a frame. This separates a repeat of the last pair from fresh data and shows that the underrun flag stays set. Timing is checked as well: in master mode, data and word-select changes must line up with the bit-clock fall. In slave mode, each data change must come exactly three system cycles after the external fall, which tells correct synchronizer depth from a short or long path.

// File: rtl/sas_pkg.sv
package sas_pkg;

  typedef enum logic {FMT_I2S = 1'b0, FMT_LJ = 1'b1} sas_fmt_e;
  typedef enum logic {SIDE_LEFT = 1'b0, SIDE_RIGHT = 1'b1} sas_side_e;

  // Channel side carried by a word-select level under a framing.
  function automatic logic side_of_lrck(logic lrck, logic lj);
    return lrck ^ lj;
  endfunction

  // Word-select level to present for a channel side under a framing.
  function automatic logic lrck_of_side(logic side, logic lj);
    return side ^ lj;
  endfunction

  // Index of the data bit (0 = MSB) in slot position pos; out of range means padding.
  function automatic int data_offset(int pos, logic lj);
    return lj ? pos : pos - 1;
  endfunction

  // Increment that stops at a ceiling.
  function automatic int sat_inc(int v, int top);
    return (v >= top) ? top : v + 1;
  endfunction

endpackage

// File: rtl/sas_sync2.sv
module sas_sync2 #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      meta_q <= '0;
      q      <= '0;
    end else begin
      meta_q <= d;
      q      <= meta_q;
    end
  end
endmodule

// File: rtl/sas_master_clk.sv
module sas_master_clk #(
  parameter int SLOT_BITS = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  input  logic tick,
  output logic sclk_q,
  output logic fall_ev,
  output logic side_nxt
);
  localparam int FRAME_BITS = 2 * SLOT_BITS;
  localparam int FW         = $clog2(FRAME_BITS);

  logic [FW-1:0] fcnt_q;
  logic [FW-1:0] fcnt_nxt;

  always_comb begin
    fall_ev  = enable && tick && sclk_q;
    fcnt_nxt = (fcnt_q == FW'(FRAME_BITS - 1)) ? '0 : fcnt_q + 1'b1;
    side_nxt = (fcnt_nxt >= FW'(SLOT_BITS));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sclk_q <= 1'b0;
      fcnt_q <= FW'(FRAME_BITS - 1);
    end else begin
      if (enable && tick) sclk_q <= ~sclk_q;
      if (fall_ev)        fcnt_q <= fcnt_nxt;
    end
  end
endmodule

// File: rtl/sas_slave_front.sv
module sas_slave_front (
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  input  logic sclk_pin,
  input  logic lrck_pin,
  output logic fall_ev,
  output logic lrck_s
);
  logic [1:0] pins_s;
  logic       sclk_s;
  logic       sclk_d;

  sas_sync2 #(.W(2)) sync_i (
    .clk  (clk),
    .rst_n(rst_n),
    .d    ({lrck_pin, sclk_pin}),
    .q    (pins_s)
  );

  assign sclk_s  = pins_s[0];
  assign lrck_s  = pins_s[1];
  assign fall_ev = enable && sclk_d && !sclk_s;

  always_ff @(posedge clk) begin
    if (!rst_n) sclk_d <= 1'b0;
    else        sclk_d <= sclk_s;
  end
endmodule

// File: rtl/sas_sample_buf.sv
module sas_sample_buf #(
  parameter int SAMPLE_W = 24
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                load_ev,
  input  logic                in_valid,
  output logic                in_ready,
  input  logic [SAMPLE_W-1:0] in_l,
  input  logic [SAMPLE_W-1:0] in_r,
  output logic [SAMPLE_W-1:0] word_l,
  output logic [SAMPLE_W-1:0] word_r,
  output logic                underrun
);
  logic                pend_v;
  logic [SAMPLE_W-1:0] pend_l, pend_r;
  logic [SAMPLE_W-1:0] act_l, act_r;
  logic                take;
  logic                fresh;

  assign in_ready = !pend_v;
  assign take     = in_valid && !pend_v;
  assign fresh    = load_ev && pend_v;
  assign word_l   = fresh ? pend_l : act_l;
  assign word_r   = fresh ? pend_r : act_r;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_v   <= 1'b0;
      pend_l   <= '0;
      pend_r   <= '0;
      act_l    <= '0;
      act_r    <= '0;
      underrun <= 1'b0;
    end else begin
      if (take) begin
        pend_v <= 1'b1;
        pend_l <= in_l;
        pend_r <= in_r;
      end
      if (load_ev) begin
        if (pend_v) begin
          act_l  <= pend_l;
          act_r  <= pend_r;
          pend_v <= 1'b0;
        end else begin
          underrun <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/sas_shifter.sv
module sas_shifter
  import sas_pkg::*;
#(
  parameter int SAMPLE_W  = 24,
  parameter int SLOT_BITS = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                fall_ev,
  input  logic                side_nxt,
  input  logic                lj,
  input  logic [SAMPLE_W-1:0] word_l,
  input  logic [SAMPLE_W-1:0] word_r,
  output logic                left_start,
  output logic                side_q,
  output logic                sdata_q
);
  localparam int PW = $clog2(SLOT_BITS + 1);

  logic [PW-1:0]       pos_q;
  logic [PW-1:0]       pos_nxt;
  logic                slot_start;
  logic                bit_nxt;
  logic [SAMPLE_W-1:0] word;

  always_comb begin
    slot_start = (side_nxt != side_q);
    left_start = fall_ev && slot_start && (side_nxt == SIDE_LEFT);
    pos_nxt    = slot_start ? '0 : PW'(sat_inc(int'(pos_q), SLOT_BITS));
    word       = side_nxt ? word_r : word_l;
  end

  always_comb begin
    int                  off;
    logic [SAMPLE_W-1:0] sh;
    off     = data_offset(int'(pos_nxt), lj);
    sh      = '0;
    bit_nxt = 1'b0;
    if (off >= 0 && off < SAMPLE_W) begin
      sh      = word >> (SAMPLE_W - 1 - off);
      bit_nxt = sh[0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      side_q  <= SIDE_RIGHT;
      pos_q   <= PW'(SLOT_BITS);
      sdata_q <= 1'b0;
    end else if (fall_ev) begin
      side_q  <= side_nxt;
      pos_q   <= pos_nxt;
      sdata_q <= bit_nxt;
    end
  end
endmodule

// File: rtl/stereo_serial_tx.sv
module stereo_serial_tx
  import sas_pkg::*;
#(
  parameter int SAMPLE_W  = 24,
  parameter int SLOT_BITS = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                master_mode,
  input  logic                fmt_lj,
  input  logic                sclk_tick,
  input  logic                sclk_in,
  input  logic                lrck_in,
  input  logic                smp_valid,
  output logic                smp_ready,
  input  logic [SAMPLE_W-1:0] smp_left,
  input  logic [SAMPLE_W-1:0] smp_right,
  output logic                sclk_out,
  output logic                lrck_out,
  output logic                clk_drive_en,
  output logic                sdata_out,
  output logic                underrun
);
  logic                m_sclk, m_fall, m_side;
  logic                s_fall, s_lrck;
  logic                fall_ev, side_nxt;
  logic                left_start, side_q;
  logic [SAMPLE_W-1:0] word_l, word_r;

  sas_master_clk #(.SLOT_BITS(SLOT_BITS)) mclk_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .enable  (master_mode),
    .tick    (sclk_tick),
    .sclk_q  (m_sclk),
    .fall_ev (m_fall),
    .side_nxt(m_side)
  );

  sas_slave_front sfront_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .enable  (!master_mode),
    .sclk_pin(sclk_in),
    .lrck_pin(lrck_in),
    .fall_ev (s_fall),
    .lrck_s  (s_lrck)
  );

  assign fall_ev  = master_mode ? m_fall : s_fall;
  assign side_nxt = master_mode ? m_side : side_of_lrck(s_lrck, fmt_lj);

  sas_sample_buf #(.SAMPLE_W(SAMPLE_W)) buf_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .load_ev (left_start),
    .in_valid(smp_valid),
    .in_ready(smp_ready),
    .in_l    (smp_left),
    .in_r    (smp_right),
    .word_l  (word_l),
    .word_r  (word_r),
    .underrun(underrun)
  );

  sas_shifter #(.SAMPLE_W(SAMPLE_W), .SLOT_BITS(SLOT_BITS)) shift_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .fall_ev   (fall_ev),
    .side_nxt  (side_nxt),
    .lj        (fmt_lj),
    .word_l    (word_l),
    .word_r    (word_r),
    .left_start(left_start),
    .side_q    (side_q),
    .sdata_q   (sdata_out)
  );

  assign sclk_out     = master_mode ? m_sclk : 1'b0;
  assign lrck_out     = master_mode ? lrck_of_side(side_q, fmt_lj) : 1'b0;
  assign clk_drive_en = master_mode;
endmodule

// File: rtl/stereo_serial_tx_chk.sv
module stereo_serial_tx_chk (
  input logic clk,
  input logic rst_n,
  input logic master_mode,
  input logic sclk_tick,
  input logic sclk_out,
  input logic sdata_out,
  input logic fall_ev,
  input logic smp_valid,
  input logic smp_ready,
  input logic underrun
);
  // R4 R8
  sdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !fall_ev |=> $stable(sdata_out));

  // R5
  sclk_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (master_mode && !sclk_tick) |=> $stable(sclk_out));

  // R6
  ready_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_valid && smp_ready) |=> !smp_ready);

  // R6
  ready_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(smp_ready) |-> $past(smp_valid));

  // R7
  underrun_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    underrun |=> underrun);

  // R7
  underrun_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(underrun) |-> $past(fall_ev));
endmodule

bind stereo_serial_tx stereo_serial_tx_chk chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .master_mode(master_mode),
  .sclk_tick  (sclk_tick),
  .sclk_out   (sclk_out),
  .sdata_out  (sdata_out),
  .fall_ev    (fall_ev),
  .smp_valid  (smp_valid),
  .smp_ready  (smp_ready),
  .underrun   (underrun)
);

// File: tb/stereo_serial_tx_tb_top.sv
module stereo_serial_tx_tb_top;
  localparam int CLK_P   = 10;
  localparam int SW      = 24;
  localparam int SLOT    = 32;
  localparam int TICKDIV = 4;
  localparam int SHALF   = 8;
  localparam int WDOG    = 120000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic master_mode = 1'b1, fmt_lj = 1'b0, sclk_tick = 1'b0;
  logic sclk_drv = 1'b0, lrck_drv = 1'b1;
  logic smp_valid = 1'b0, smp_ready;
  logic [SW-1:0] smp_left = '0, smp_right = '0;
  logic sclk_out, lrck_out, clk_drive_en, sdata_out, underrun;

  stereo_serial_tx dut_i (
    .clk(clk), .rst_n(rst_n), .master_mode(master_mode), .fmt_lj(fmt_lj),
    .sclk_tick(sclk_tick), .sclk_in(sclk_drv), .lrck_in(lrck_drv),
    .smp_valid(smp_valid), .smp_ready(smp_ready), .smp_left(smp_left),
    .smp_right(smp_right), .sclk_out(sclk_out), .lrck_out(lrck_out),
    .clk_drive_en(clk_drive_en), .sdata_out(sdata_out), .underrun(underrun)
  );

  initial forever #(CLK_P/2) clk = ~clk;

  typedef struct { logic [SW-1:0] l; logic [SW-1:0] r; } pair_t;
  pair_t pendq[$];
  pair_t cur;

  int nchk = 0, nfail = 0;
  int cyc = 0, since_fall = 100, last_toggle = -1;
  int scnt = 0, fall_cnt = 0, pos = 0, rises = 0, left_count = 0, skip_at = 0, fidx = 0;
  bit run = 0, clr_valid = 0, have_prev = 0, synced = 0, slot_left = 0, exp_under = 0;
  logic prev_line = 0, prev_sd = 0, prev_lrout = 0, prev_lr = 0;
  logic [SW-1:0] word = '0;

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [SW-1:0] pattern(int k);
    case (k % 6)
      0: return 24'h800000;
      1: return 24'h7FFFFF;
      2: return 24'hA5A5A5;
      3: return 24'h000001;
      4: return 24'hFFFFFF;
      default: return SW'($urandom);
    endcase
  endfunction

  task automatic feed();
    pair_t p;
    p.l = pattern(fidx);
    p.r = pattern(fidx + 3);
    fidx++;
    smp_left  = p.l;
    smp_right = p.r;
    smp_valid = 1'b1;
    clr_valid = 1'b1;
    pendq.push_back(p);
  endtask

  task automatic on_rise(logic lr);
    if (have_prev && lr != prev_lr) begin
      if (synced) begin
        logic [SW-1:0] expw;
        expw = slot_left ? cur.l : cur.r;
        chk(rises == SLOT, "R5", "bit periods per slot", rises, SLOT);
        chk(word == expw, fmt_lj ? "R1 R3" : "R1 R2", "received word", word, expw);
      end
      synced = 1; pos = 0; rises = 0; word = '0;
      slot_left = (lr == fmt_lj);
      if (slot_left) begin
        left_count++;
        if (pendq.size() > 0) cur = pendq.pop_front();
        else exp_under = 1;
        chk(underrun == exp_under, "R7", "underrun flag", underrun, exp_under);
        chk(smp_ready == 1'b1, "R6", "ready after left-slot take", smp_ready, 1);
        if (left_count != skip_at) feed();
      end
    end else begin
      pos++;
    end
    rises++;
    if (synced) begin
      int off;
      off = fmt_lj ? pos : pos - 1;
      if (off >= 0 && off < SW) word[SW-1-off] = sdata_out;
      else chk(sdata_out == 1'b0, "R1", "padding bit", sdata_out, 0);
    end
    prev_lr = lr;
    have_prev = 1;
  endtask

  task automatic monitor();
    logic line, lr;
    line = master_mode ? sclk_out : sclk_drv;
    lr   = master_mode ? lrck_out : lrck_drv;
    if (run) begin
      if (master_mode) begin
        if (line != prev_line) begin
          if (last_toggle >= 0)
            chk(cyc - last_toggle == TICKDIV, "R5", "cycles between toggles", cyc - last_toggle, TICKDIV);
          last_toggle = cyc;
        end
        if (sdata_out !== prev_sd || lrck_out !== prev_lrout)
          chk(prev_line == 1'b1 && line == 1'b0, "R4", "change away from bit-clock fall", line, 0);
      end else if (sdata_out !== prev_sd) begin
        chk(since_fall == 3, "R8", "cycles from external fall to data change", since_fall, 3);
      end
      if (prev_line == 1'b0 && line == 1'b1) on_rise(lr);
    end
    prev_line  = line;
    prev_sd    = sdata_out;
    prev_lrout = lrck_out;
  endtask

  task automatic drive();
    if (master_mode) begin
      sclk_tick = run && (cyc % TICKDIV == 0);
    end else if (run) begin
      scnt++;
      if (scnt == SHALF) begin
        scnt = 0;
        sclk_drv = ~sclk_drv;
        if (sclk_drv == 1'b0) begin
          since_fall = 0;
          fall_cnt++;
          if (fall_cnt == SLOT) begin
            fall_cnt = 0;
            lrck_drv = ~lrck_drv;
          end
        end
      end
    end
  endtask

  task automatic step();
    @(negedge clk);
    cyc++;
    since_fall++;
    if (clr_valid) begin
      chk(smp_ready == 1'b0, "R6", "ready after accept", smp_ready, 0);
      smp_valid = 1'b0;
      clr_valid = 1'b0;
    end
    monitor();
    drive();
  endtask

  task automatic run_phase(bit mst, bit lj, int nframes, int skip);
    pair_t p;
    run = 0; sclk_tick = 0; smp_valid = 0; clr_valid = 0;
    rst_n = 0;
    master_mode = mst; fmt_lj = lj;
    sclk_drv = 0; lrck_drv = ~lj; scnt = 0; fall_cnt = 0;
    repeat (3) step();
    rst_n = 1;
    step();
    chk(underrun == 1'b0, "R7", "underrun after reset", underrun, 0);
    chk(smp_ready == 1'b1, "R6", "ready after reset", smp_ready, 1);
    chk(sdata_out == 1'b0, "R1", "data after reset", sdata_out, 0);
    chk(clk_drive_en == mst, "R5", "drive enable", clk_drive_en, mst);
    chk(sclk_out == 1'b0, "R5", "bit clock after reset", sclk_out, 0);
    if (mst) chk(lrck_out == ~lj, lj ? "R3" : "R2", "word select after reset", lrck_out, ~lj);
    pendq.delete();
    have_prev = 0; synced = 0; exp_under = 0; left_count = 0; skip_at = skip;
    pos = 0; rises = 0; last_toggle = -1; since_fall = 100;
    cur.l = '0; cur.r = '0;
    p.l = pattern(fidx); p.r = pattern(fidx + 2); fidx++;
    smp_left = p.l; smp_right = p.r; smp_valid = 1;
    pendq.push_back(p);
    step();
    smp_valid = 0;
    chk(smp_ready == 1'b0, "R6", "ready after preload", smp_ready, 0);
    prev_line = master_mode ? sclk_out : sclk_drv;
    prev_sd = sdata_out; prev_lrout = lrck_out;
    run = 1;
    while (left_count <= nframes) step();
    run = 0;
    sclk_tick = 0;
    if (skip > 0) chk(underrun == 1'b1, "R7", "underrun held", underrun, 1);
    repeat (4) step();
  endtask

  initial begin
    #(CLK_P * WDOG);
    nfail++;
    $display("FAIL watchdog: actual=%0d expected=0", cyc);
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end

  initial begin
    run_phase(1'b1, 1'b0, 6, 3);
    run_phase(1'b1, 1'b1, 5, 0);
    run_phase(1'b0, 1'b0, 4, 2);
    run_phase(1'b0, 1'b1, 4, 0);
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end
endmodule